// File: doc/BRIEF.md
# Comparator Output Sample Filter

This block cleans up the raw, asynchronous output of an analog comparator before the edge-detection stage sees it. The raw bit first passes through a two-register synchronizer. A programmable prescaler then produces a sample strobe every `filt_per` bus clocks, and an agreement counter lets the filtered output move to a new level only after `filt_cnt` consecutive samples have shown that level. Any shorter excursion is absorbed and never reaches the output.

Sampling runs only while the block is enabled, the window input is high and the internal sample source is selected. When the window closes, the prescaler and the agreement count freeze, and the output keeps its value. When the block is disabled, the output is forced low and every counter returns to zero. The analog delay is taken as zero. From a change on the raw input, the filtered output always settles within `filt_cnt × filt_per + 2` bus clocks.

Top module: `cmp_sample_filter`

## Requirements
- R1: After synchronous reset, `cout_filt` is 0.
- R2: While sampling is active, a sample is taken every `filt_per` bus clocks. A `filt_per` value of 0 is treated as 1.
- R3: `cout_filt` changes only after `filt_cnt` consecutive samples differ from its current value. A sample equal to `cout_filt` restarts the count, so a pulse shorter than `filt_cnt` samples is rejected.
- R4: When `raw_in` changes between two clock edges and then stays steady, `cout_filt` follows within `filt_cnt × filt_per + 2` rising clock edges.
- R5: `cout_filt` never follows sooner than `(filt_cnt − 1) × filt_per + 3` rising clock edges after the change on `raw_in`.
- R6: While `win_en` is 0, sampling is suspended and `cout_filt` holds its value. Filtering resumes when `win_en` returns to 1.
- R7: While `ext_sel` is 1, internal sampling is suspended and `cout_filt` holds its value.
- R8: While `mod_en` is 0, `cout_filt` is 0 from the next clock edge on, and the prescaler and agreement counters are cleared.
- R9: With `filt_cnt` equal to 0 or 1, the first sample that differs from `cout_filt` changes it. With `filt_per` = 1, this happens on the third rising edge after the change on `raw_in`.
- R10: `raw_in` reaches the sampling point through exactly two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Raw asynchronous comparator bit |
| win_en | input | 1 | Window gate; sampling occurs only while high |
| mod_en | input | 1 | Block enable; low forces output 0 and clears counters |
| ext_sel | input | 1 | High selects an external sample source, which suspends internal sampling |
| filt_cnt | input | CNT_W (3) | Number of consecutive agreeing samples required |
| filt_per | input | PER_W (8) | Sample period in bus clocks |
| cout_filt | output | 1 | Filtered comparator output |

## Verification
The bench builds the block with its defaults, CNT_W = 3 and PER_W = 8. These widths cover every agreement count from 2 to 7 and sample periods up to 255, so both ends of the latency window can be measured, including the largest case of 7 × 255 + 2 edges. A table of count and period pairs checks R4 and R5 on both rising and falling transitions, with the prescaler phase left wherever the previous case ended. Directed cases then cover glitch rejection and counter restart, freezing by the window and by the external-source select, disabling, and the unfiltered setting.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  typedef enum logic [1:0] {
    GATE_OFF  = 2'd0,
    GATE_HOLD = 2'd1,
    GATE_RUN  = 2'd2
  } gate_e;

  function automatic gate_e gate_of(input logic en, input logic win, input logic ext);
    if (!en)             return GATE_OFF;
    else if (win && !ext) return GATE_RUN;
    else                 return GATE_HOLD;
  endfunction

endpackage

// File: rtl/cmpf_sync.sv
module cmpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];

  assert_sync_depth_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (d_out == $past(d_in, 2)))
    else $error("sync depth");

endmodule

// File: rtl/cmpf_prescaler.sv
module cmpf_prescaler #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last;

  always_comb begin
    last = (period == '0) ? '0 : period - 1'b1;
  end

  assign tick = active && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (active) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  assert_tick_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (cnt_q == '0))
    else $error("prescaler did not restart");

  assert_frozen_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!active && !clr) |=> $stable(cnt_q))
    else $error("prescaler moved while idle");

  assert_cleared_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0))
    else $error("prescaler not cleared");

endmodule

// File: rtl/cmpf_agree.sv
module cmpf_agree #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             sample,
  input  logic [CNT_W-1:0] need,
  output logic             level
);

  localparam int W = CNT_W + 1;

  logic [CNT_W-1:0] run_q;
  logic [W-1:0]     need_eff;
  logic [W-1:0]     run_next;

  always_comb begin
    need_eff = (need <= 1) ? W'(1) : W'(need);
    run_next = W'(run_q) + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level <= 1'b0;
      run_q <= '0;
    end else if (tick) begin
      if (sample == level) begin
        run_q <= '0;
      end else if (run_next >= need_eff) begin
        level <= sample;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_off_forces_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level == 1'b0 && run_q == '0))
    else $error("disable did not clear");

  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(level))
    else $error("output moved without sample");

  assert_match_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && sample == level) |=> (run_q == '0))
    else $error("matching sample did not restart count");

endmodule

// File: rtl/cmp_sample_filter.sv
module cmp_sample_filter
  import cmpf_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic             win_en,
  input  logic             mod_en,
  input  logic             ext_sel,
  input  logic [CNT_W-1:0] filt_cnt,
  input  logic [PER_W-1:0] filt_per,
  output logic             cout_filt
);

  localparam int SYNC_STAGES = 2;

  gate_e gate;
  logic  synced;
  logic  tick;

  assign gate = gate_of(mod_en, win_en, ext_sel);

  cmpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_in),
    .d_out (synced)
  );

  cmpf_prescaler #(.PER_W(PER_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clr    (gate == GATE_OFF),
    .active (gate == GATE_RUN),
    .period (filt_per),
    .tick   (tick)
  );

  cmpf_agree #(.CNT_W(CNT_W)) u_agree (
    .clk    (clk),
    .rst    (rst),
    .en     (gate != GATE_OFF),
    .tick   (tick),
    .sample (synced),
    .need   (filt_cnt),
    .level  (cout_filt)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    $past(rst) |-> (cout_filt == 1'b0))
    else $error("reset state");

  assert_ext_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (mod_en && ext_sel) |=> $stable(cout_filt) || !mod_en)
    else $error("output moved with external source selected");

endmodule

// File: tb/cmp_sample_filter_tb.sv
module cmp_sample_filter_tb;

  logic       clk = 0;
  logic       rst = 1;
  logic       raw_in = 0, win_en = 1, mod_en = 1, ext_sel = 0;
  logic [2:0] filt_cnt = 3'd2;
  logic [7:0] filt_per = 8'd1;
  logic       cout_filt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_sample_filter u_dut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .win_en(win_en), .mod_en(mod_en),
    .ext_sel(ext_sel), .filt_cnt(filt_cnt), .filt_per(filt_per), .cout_filt(cout_filt)
  );

  // {cnt[3:0], per[7:0], bound[11:0]} with bound = cnt*per+2
  localparam logic [23:0] VEC [12] = '{
    {4'd2, 8'd1,   12'd4},
    {4'd3, 8'd1,   12'd5},
    {4'd4, 8'd2,   12'd10},
    {4'd5, 8'd3,   12'd17},
    {4'd6, 8'd5,   12'd32},
    {4'd7, 8'd4,   12'd30},
    {4'd2, 8'd255, 12'd512},
    {4'd3, 8'd16,  12'd50},
    {4'd4, 8'd7,   12'd30},
    {4'd5, 8'd1,   12'd7},
    {4'd6, 8'd2,   12'd14},
    {4'd7, 8'd255, 12'd1787}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // toggle raw at a negedge, count rising edges until output follows
  task automatic measure(input int limit, output int n);
    logic target;
    @(negedge clk);
    raw_in = ~cout_filt;
    target = raw_in;
    n = 0;
    while (cout_filt != target && n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    cycles(4);
    chk(cout_filt == 0, "R1 reset", cout_filt, 0);
    @(negedge clk) rst = 0;
    cycles(3);
    chk(cout_filt == 0, "R1 after release", cout_filt, 0);

    // R2 R4 R5: latency window across counts and periods, both directions
    foreach (VEC[k]) begin
      int c, p, b, lo;
      c = int'(VEC[k][23:20]);
      p = int'(VEC[k][19:12]);
      b = int'(VEC[k][11:0]);
      lo = (c - 1) * p + 3;
      filt_cnt = 3'(c);
      filt_per = 8'(p);
      for (int d = 0; d < 2; d++) begin
        measure(b + 40, n);
        chk(n <= b, "R4 upper bound", n, b);
        chk(n >= lo, "R5 lower bound", n, lo);
        chk(cout_filt == raw_in, "R2 output followed", cout_filt, raw_in);
        cycles(3);
      end
    end

    // R3 glitch rejection: 2-cycle pulse with cnt=4 per=1
    filt_cnt = 3'd4; filt_per = 8'd1;
    @(negedge clk) raw_in = 0;
    cycles(10);
    @(negedge clk) raw_in = 1;
    cycles(2);
    raw_in = 0;
    cycles(10);
    chk(cout_filt == 0, "R3 short pulse rejected", cout_filt, 0);

    // R3 restart: 3 high, 1 low, 3 high never reaches 4 in a row
    raw_in = 1; cycles(3);
    raw_in = 0; cycles(1);
    raw_in = 1; cycles(3);
    raw_in = 0; cycles(10);
    chk(cout_filt == 0, "R3 disagreeing sample restarts", cout_filt, 0);

    // R6 window low freezes
    filt_cnt = 3'd2;
    win_en = 0;
    raw_in = 1;
    cycles(20);
    chk(cout_filt == 0, "R6 window low holds", cout_filt, 0);
    win_en = 1;
    cycles(6);
    chk(cout_filt == 1, "R6 resumes after window", cout_filt, 1);

    // R7 external source select freezes
    ext_sel = 1;
    raw_in = 0;
    cycles(20);
    chk(cout_filt == 1, "R7 ext select holds", cout_filt, 1);
    ext_sel = 0;
    cycles(6);
    chk(cout_filt == 0, "R7 resumes after ext select", cout_filt, 0);

    // R8 disable forces low
    raw_in = 1;
    cycles(6);
    chk(cout_filt == 1, "R8 precondition high", cout_filt, 1);
    mod_en = 0;
    cycles(1);
    chk(cout_filt == 0, "R8 disable forces low", cout_filt, 0);
    cycles(10);
    chk(cout_filt == 0, "R8 stays low while disabled", cout_filt, 0);
    mod_en = 1;
    cycles(6);
    chk(cout_filt == 1, "R8 re-enable follows input", cout_filt, 1);

    // R9 R10: unfiltered setting, per=1 -> exactly 3 edges
    filt_cnt = 3'd1;
    measure(20, n);
    chk(n == 3, "R9 R10 cnt=1 latency", n, 3);
    filt_cnt = 3'd0;
    cycles(3);
    measure(20, n);
    chk(n == 3, "R9 R10 cnt=0 latency", n, 3);

    // R1 reset mid-run
    @(negedge clk) raw_in = 1;
    cycles(6);
    rst = 1;
    cycles(1);
    chk(cout_filt == 0, "R1 reset clears output", cout_filt, 0);
    rst = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule